// File: doc/BRIEF.md
# Multi-Channel Carrier Phase Accumulator Bank

The block holds one carrier numerically controlled oscillator for each channel of a receiver correlator. Every channel keeps a 27-bit phase accumulator. On each sample-clock cycle in which the sample enable is high, the accumulator adds that channel's 26-bit live phase increment. The top phase bits drive a downstream local-oscillator mapper. A one-cycle pulse marks every completed carrier cycle, so the output frequency is the increment times a fixed minimum frequency step.

The increment is loaded over a 16-bit write port in two words. A high-word strobe stores increment bits 25..16 in a per-channel holding buffer and does not touch the running oscillator. A low-word strobe then commits the buffered high bits and the new low bits to the live increment in a single step. The scope input sends each strobe to one channel, to the channels set in a mask, or to every channel, so one write can retune many channels at once.

Top module: `carrier_nco_bank`

## Requirements
- R1: After reset every accumulator, holding buffer and live increment is zero. `phase_msb` and `cycle_pulse` read zero, and they stay zero while no write occurs.
- R2: A high-word strobe loads `wr_data[9:0]` into the holding buffer of each targeted channel as increment bits 25..16. `wr_data[15:10]` is ignored.
- R3: A high-word strobe alone leaves the live increment, and therefore the phase progression, unchanged.
- R4: A low-word strobe sets the live increment of each targeted channel to {holding buffer, `wr_data[15:0]`} at the strobe's clock edge. Accumulation with the new value starts at the next enabled edge. When both strobes occur in the same cycle, the commit uses the buffer value from before that edge.
- R5: A low-word strobe with no earlier high-word strobe uses the current buffer contents, which are zero after reset.
- R6: Scope code 2'b00 targets only channel `wr_chan`. Code 2'b11 targets no channel.
- R7: Scope code 2'b01 targets the channels whose bits are set in `wr_mask`, sampled at the strobe edge.
- R8: Scope code 2'b10 targets every channel.
- R9: On each edge with `sample_en` high, the accumulator adds the live increment modulo 2^27. With `sample_en` low, the accumulator holds and no pulse is produced.
- R10: `cycle_pulse[c]` is high for exactly the cycle that follows an edge on which channel c's addition carried out of bit 26. Two pulses never occur back to back.
- R11: `phase_msb` field c (bits c*10+9..c*10) equals accumulator bits 26..17 of channel c.
- R12: With an increment of 2^25, a channel produces exactly 16 pulses in any 64 consecutive enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_en | input | 1 | Advance all accumulators this cycle |
| wr_hi | input | 1 | High-word write strobe |
| wr_lo | input | 1 | Low-word write strobe |
| wr_scope | input | 2 | Target scope: 00 one, 01 mask, 10 all, 11 none |
| wr_chan | input | 2 | Channel index for scope 00 |
| wr_mask | input | 4 | Channel mask for scope 01 |
| wr_data | input | 16 | Write data word |
| phase_msb | output | 40 | Per-channel top phase bits, 10 bits per channel |
| cycle_pulse | output | 4 | Per-channel carrier-cycle pulse |

## Verification
A cycle-accurate bench model predicts every output on every cycle, and the bench compares the block against it. The stimulus covers a high write that carries junk in its upper data bits, a lone low write from a zero buffer, same-cycle high and low strobes, and masked, broadcast and no-target writes. Each of these would diverge from the model on a specific fault: leaked bits, an early commit, a wrong buffer age, or a wrong fan-out. An all-ones increment with long runs checks the wrap and the carry timing, and an idle stretch checks the hold. A fixed 2^25 increment checks the pulse count against the exact expected rate.

// File: rtl/nco_pkg.sv
package nco_pkg;
   typedef enum logic [1:0] {
      SCOPE_ONE   = 2'b00,
      SCOPE_MULTI = 2'b01,
      SCOPE_ALL   = 2'b10,
      SCOPE_NONE  = 2'b11
   } wr_scope_e;
endpackage

// File: rtl/nco_write_target.sv
module nco_write_target
   import nco_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hi_stb,
   input  logic              lo_stb,
   input  logic [1:0]        scope,
   input  logic [IDX_W-1:0]  chan,
   input  logic [NUM_CH-1:0] mask,
   output logic [NUM_CH-1:0] hi_sel,
   output logic [NUM_CH-1:0] lo_sel
);
   logic [NUM_CH-1:0] one_dec;
   logic [NUM_CH-1:0] tgt;

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
         assign one_dec[i] = (chan == IDX_W'(i));
      end
   endgenerate

   always_comb begin
      case (wr_scope_e'(scope))
         SCOPE_ONE:   tgt = one_dec;
         SCOPE_MULTI: tgt = mask;
         SCOPE_ALL:   tgt = '1;
         default:     tgt = '0;
      endcase
   end

   assign hi_sel = tgt & {NUM_CH{hi_stb}};
   assign lo_sel = tgt & {NUM_CH{lo_stb}};

   AST_SINGLE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_stb && scope == 2'b00 && int'(chan) < NUM_CH) |-> $countones(lo_sel) == 1); // R6
   AST_NONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'b11) |-> (hi_sel == '0 && lo_sel == '0)); // R6
   AST_MULTI_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'b01) |-> ((hi_sel & ~mask) == '0 && (lo_sel & ~mask) == '0)); // R7
   AST_ALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (scope == 2'b10 && lo_stb) |-> (&lo_sel)); // R8
endmodule

// File: rtl/nco_incr_reg.sv
module nco_incr_reg #(
   parameter int INC_W = 26,
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hi_sel,
   input  logic             lo_sel,
   input  logic [BUS_W-1:0] data,
   output logic [INC_W-1:0] incr
);
   localparam int HI_W = INC_W - BUS_W;

   logic [HI_W-1:0] buf_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_q <= '0;
         incr  <= '0;
      end else begin
         if (hi_sel) buf_q <= data[HI_W-1:0];
         if (lo_sel) incr  <= {buf_q, data};
      end
   end

   AST_HI_LOADS_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      hi_sel |=> buf_q == $past(data[HI_W-1:0])); // R2
   AST_LIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !lo_sel |=> $stable(incr)); // R3
   AST_LO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      lo_sel |=> incr == {$past(buf_q), $past(data)}); // R4
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int ACC_W = 27,
   parameter int INC_W = 26,
   parameter int PH_W  = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [INC_W-1:0] incr,
   output logic [PH_W-1:0]  phase,
   output logic             pulse
);
   localparam int SUM_W = ACC_W + 1;

   logic [ACC_W-1:0] acc;
   logic [SUM_W-1:0] sum;

   assign sum = {1'b0, acc} + SUM_W'(incr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         pulse <= 1'b0;
      end else if (en) begin
         acc   <= sum[ACC_W-1:0];
         pulse <= sum[ACC_W];
      end else begin
         pulse <= 1'b0;
      end
   end

   assign phase = acc[ACC_W-1 -: PH_W];

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(acc) && !pulse)); // R9
   AST_PULSE_IS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (pulse == (acc < $past(acc)))); // R10
   AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse); // R10
endmodule

// File: rtl/carrier_nco_bank.sv
module carrier_nco_bank #(
   parameter int NUM_CH = 4,
   parameter int ACC_W  = 27,
   parameter int INC_W  = 26,
   parameter int BUS_W  = 16,
   parameter int PH_W   = 10,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sample_en,
   input  logic                   wr_hi,
   input  logic                   wr_lo,
   input  logic [1:0]             wr_scope,
   input  logic [IDX_W-1:0]       wr_chan,
   input  logic [NUM_CH-1:0]      wr_mask,
   input  logic [BUS_W-1:0]       wr_data,
   output logic [NUM_CH*PH_W-1:0] phase_msb,
   output logic [NUM_CH-1:0]      cycle_pulse
);
   generate
      if (INC_W >= ACC_W) begin : g_bad_inc
         $error("increment must be narrower than the accumulator");
      end
      if (INC_W <= BUS_W || INC_W > 2 * BUS_W) begin : g_bad_split
         $error("increment must span exactly two bus words");
      end
      if (PH_W < 1 || PH_W > ACC_W) begin : g_bad_phase
         $error("phase output width out of range");
      end
      if (NUM_CH < 1) begin : g_bad_ch
         $error("at least one channel required");
      end
   endgenerate

   logic [NUM_CH-1:0] hi_sel;
   logic [NUM_CH-1:0] lo_sel;

   nco_write_target #(
      .NUM_CH (NUM_CH),
      .IDX_W  (IDX_W)
   ) u_target (
      .clk    (clk),
      .rst_n  (rst_n),
      .hi_stb (wr_hi),
      .lo_stb (wr_lo),
      .scope  (wr_scope),
      .chan   (wr_chan),
      .mask   (wr_mask),
      .hi_sel (hi_sel),
      .lo_sel (lo_sel)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [INC_W-1:0] incr;

         nco_incr_reg #(
            .INC_W (INC_W),
            .BUS_W (BUS_W)
         ) u_incr (
            .clk    (clk),
            .rst_n  (rst_n),
            .hi_sel (hi_sel[c]),
            .lo_sel (lo_sel[c]),
            .data   (wr_data),
            .incr   (incr)
         );

         nco_phase_acc #(
            .ACC_W (ACC_W),
            .INC_W (INC_W),
            .PH_W  (PH_W)
         ) u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (sample_en),
            .incr  (incr),
            .phase (phase_msb[c*PH_W +: PH_W]),
            .pulse (cycle_pulse[c])
         );
      end
   endgenerate

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (cycle_pulse == '0 && phase_msb == '0)); // R1
endmodule

// File: tb/test_carrier_nco_bank.sv
`timescale 1ns/1ps
module test_carrier_nco_bank;
   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_en = 1'b0;
   logic        wr_hi = 1'b0;
   logic        wr_lo = 1'b0;
   logic [1:0]  wr_scope = 2'b00;
   logic [1:0]  wr_chan = '0;
   logic [3:0]  wr_mask = '0;
   logic [15:0] wr_data = '0;
   logic [39:0] phase_msb;
   logic [3:0]  cycle_pulse;

   always #2 clk = ~clk;

   carrier_nco_bank i_carrier_nco_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .sample_en   (sample_en),
      .wr_hi       (wr_hi),
      .wr_lo       (wr_lo),
      .wr_scope    (wr_scope),
      .wr_chan     (wr_chan),
      .wr_mask     (wr_mask),
      .wr_data     (wr_data),
      .phase_msb   (phase_msb),
      .cycle_pulse (cycle_pulse)
   );

   typedef struct {
      logic [39:0] ph;
      logic [3:0]  pl;
      string       req;
   } exp_t;

   exp_t  q[$];
   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur_req = "R1";

   logic [26:0] m_acc [NCH];
   logic [25:0] m_inc [NCH];
   logic [9:0]  m_buf [NCH];

   // reference model: updated at each rising edge from stable inputs
   always @(posedge clk) begin
      exp_t e;
      logic [3:0] tgt;
      logic [27:0] s;
      if (!rst_n) begin
         for (int c = 0; c < NCH; c++) begin
            m_acc[c] = '0; m_inc[c] = '0; m_buf[c] = '0;
         end
         e.pl = '0;
      end else begin
         for (int c = 0; c < NCH; c++) begin
            if (sample_en) begin
               s = {1'b0, m_acc[c]} + {2'b0, m_inc[c]};
               m_acc[c] = s[26:0];
               e.pl[c] = s[27];
            end else begin
               e.pl[c] = 1'b0;
            end
         end
         case (wr_scope)
            2'b00: tgt = 4'b0001 << wr_chan;
            2'b01: tgt = wr_mask;
            2'b10: tgt = 4'b1111;
            default: tgt = 4'b0000;
         endcase
         for (int c = 0; c < NCH; c++) begin
            if (tgt[c] && wr_lo) m_inc[c] = {m_buf[c], wr_data};
            if (tgt[c] && wr_hi) m_buf[c] = wr_data[9:0];
         end
      end
      for (int c = 0; c < NCH; c++) e.ph[c*10 +: 10] = m_acc[c][26:17];
      e.req = cur_req;
      q.push_back(e);
   end

   // monitor: compares away from the active edge
   always @(negedge clk) begin
      exp_t e;
      if (q.size() > 0 && !done) begin
         e = q.pop_front();
         total++;
         if (phase_msb !== e.ph || cycle_pulse !== e.pl) begin
            bad++;
            $display("FAIL %s: phase=%h pulse=%b expected phase=%h pulse=%b",
                     e.req, phase_msb, cycle_pulse, e.ph, e.pl);
         end
      end
   end

   task automatic wr(input bit hi, input bit lo, input logic [1:0] sc,
                     input logic [1:0] ch, input logic [3:0] mk,
                     input logic [15:0] d, input string req);
      cur_req = req;
      wr_hi = hi; wr_lo = lo; wr_scope = sc; wr_chan = ch; wr_mask = mk; wr_data = d;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0; wr_mask = 4'b0000; wr_data = 16'h0000;
   endtask

   task automatic idle(input int n, input string req);
      cur_req = req;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cnt;
      @(negedge clk);
      idle(4, "R1");                           // R1 reset state
      rst_n = 1'b1; sample_en = 1'b1;
      idle(3, "R1");                           // R1 stays zero without writes
      wr(1, 0, 2'b00, 2'd0, 4'h0, 16'hFC12, "R2"); // R2 upper data bits junk
      idle(4, "R3");                           // R3 live increment untouched
      wr(0, 1, 2'b00, 2'd0, 4'h0, 16'h3456, "R4");
      idle(10, "R11");                         // R11 phase field mapping
      wr(0, 1, 2'b00, 2'd1, 4'h0, 16'h0100, "R5"); // R5 zero buffer
      idle(6, "R5");
      wr(1, 0, 2'b01, 2'd0, 4'b1010, 16'h03FF, "R7");
      wr(0, 1, 2'b01, 2'd0, 4'b1010, 16'hFFFF, "R7"); // R7 masked channels
      idle(8, "R7");
      wr(1, 0, 2'b10, 2'd0, 4'h0, 16'h0155, "R8");
      wr(0, 1, 2'b10, 2'd0, 4'h0, 16'h8000, "R8");    // R8 broadcast
      idle(6, "R8");
      wr(1, 1, 2'b00, 2'd2, 4'h0, 16'h2AAA, "R4");    // R4 same-cycle strobes
      idle(6, "R4");
      wr(1, 1, 2'b11, 2'd3, 4'hF, 16'hFFFF, "R6");    // R6 no target
      wr(0, 1, 2'b00, 2'd3, 4'h0, 16'h7777, "R6");    // R6 single channel
      idle(6, "R6");
      cur_req = "R9"; sample_en = 1'b0;               // R9 hold when disabled
      idle(6, "R9");
      sample_en = 1'b1;
      idle(200, "R10");                               // R10 wrap and pulses
      wr(1, 0, 2'b00, 2'd0, 4'h0, 16'h0200, "R12");
      wr(0, 1, 2'b00, 2'd0, 4'h0, 16'h0000, "R12");
      idle(2, "R12");
      cnt = 0;
      for (int k = 0; k < 64; k++) begin
         @(negedge clk);
         if (cycle_pulse[0]) cnt++;
      end
      total++;
      if (cnt != 16) begin                            // R12 pulse rate
         bad++;
         $display("FAIL R12: pulses=%0d expected=%0d", cnt, 16);
      end
      idle(2, "R12");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++;
         total++;
         $display("FAIL watchdog: run=%0d expected=%0d", 20000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule